// File: doc/BRIEF.md
# Buck Converter Start-up and Fault Sequencer

This block is the digital supervisor of a two-phase synchronous buck converter. Every analog decision reaches it as a one-bit flag: the supply power-on-reset comparator, the soft-start pin state, the ramp comparators, the feedback window comparators, the current-limit comparator and the thermal sensor. From these flags it decides when the soft-start ramp may run and when it must be discharged. It also decides when the error-amplifier output is clamped low, which phases may switch, when the low-side switches are forced on, when all gate drivers are parked off, and when power-good is reported.

Start-up waits for the supply and the soft-start pin. Switching is held back until the ramp has caught up with a pre-charged output. The block then runs until a fault or a disable. Over-current restarts the ramp and latches off on the third event since power-on. A filtered under-voltage latches off, but only once the ramp has finished. A filtered over-voltage clamps the output through the low-side switches for as long as it lasts. Over-temperature parks the drivers and restarts the block when the flag clears. Single-phase operation, once entered, holds until the soft-start pin is pulled low or power-on-reset drops.

Top module: `buck_guard_seq`

## Requirements
- R1: While `rst_n` is low or `por_ok` is low, the block sits in its idle state: `ramp_en`=0, `ramp_dischg`=1, `comp_pulldown`=1, `sw_en`=00, `lowside_force`=00, `drv_off_all`=1, `pwr_good`=0, `single_phase`=0. The over-current count and any fault latch are cleared.
- R2: With `por_ok` high, `ss_low` low and no over-temperature, the ramp starts (`ramp_en`=1, `ramp_dischg`=0, `drv_off_all`=0). `sw_en` stays 00 and `comp_pulldown` stays 1 until `ramp_at_fb` is seen. After that, `sw_en[0]` (phase 1) and `sw_en[1]` (phase 2) go high and `comp_pulldown` drops. Outputs are registered and follow their cause by one clock.
- R3: The under- and over-voltage flags act only after HOLD_CYC consecutive high samples. A shorter pulse has no effect, and the filtered flag drops one clock after the raw flag goes low.
- R4: Under-voltage is ignored until `ss_done` has moved the block into its run state. In the run state, a filtered under-voltage parks all drivers. The parked state holds against every input except `por_ok` going low.
- R5: While the filtered over-voltage is high and the ramp is enabled, `lowside_force`=11, `sw_en`=00 and `pwr_good`=0. This applies during soft-start too. Normal switching returns once the flag clears.
- R6: Each `oc_flag_in` event during soft-start or run parks the drivers and discharges the ramp until the flag clears. A new soft-start then follows. The OC_LIMIT-th event since power-on latches the block off. `ss_low` does not release this latch; only `por_ok` low does.
- R7: `ot_flag_in` high parks all drivers and discharges the ramp. When it clears, a fresh start-up follows.
- R8: `pwr_good` is high only in the run state while `pg_level` is high and no filtered over-voltage is present.
- R9: `one_phase_req` high or `supply2_ok` low sets `single_phase`, which forces `sw_en[1]` low. It stays set until `ss_low` is high or `por_ok` is low.
- R10: `ss_low` high during soft-start or run returns the block to its idle outputs, with `comp_pulldown`=1 and the ramp discharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply power-on-reset good |
| ss_low | input | 1 | Soft-start pin pulled low (disable) |
| ss_done | input | 1 | Soft-start ramp complete |
| ramp_at_fb | input | 1 | Ramp has reached feedback voltage |
| uv_flag_in | input | 1 | Raw under-voltage comparator |
| ov_flag_in | input | 1 | Raw over-voltage comparator |
| oc_flag_in | input | 1 | Over-current comparator |
| ot_flag_in | input | 1 | Over-temperature (hysteresis applied outside) |
| pg_level | input | 1 | Feedback above the power-good level |
| one_phase_req | input | 1 | Request for single-phase operation |
| supply2_ok | input | 1 | Second-phase input supply present |
| ramp_en | output | 1 | Soft-start ramp enable |
| ramp_dischg | output | 1 | Soft-start ramp discharge |
| comp_pulldown | output | 1 | Error-amplifier output clamp |
| sw_en | output | 2 | Per-phase switching enable, bit 0 = phase 1 |
| lowside_force | output | 2 | Per-phase low-side force-on |
| drv_off_all | output | 1 | All gate drivers off |
| pwr_good | output | 1 | Power-good flag |
| single_phase | output | 1 | Single-phase status |

## Verification
The flags are stepped through a start-up with and without a pre-charged output, so that the hold-off on `ramp_at_fb` is seen apart from the ramp enable. Under-voltage is applied once during soft-start and once in run, which separates blanking from latching. A pulse one clock shorter than the filter window is also applied, which separates filtering from blanking. Over-current is raised repeatedly with an over-temperature restart in between, which shows that the count survives restarts and that `ss_low` cannot release the latch while `por_ok` can. Over-voltage is stepped clock by clock to pin down the filter length and its non-latching release.

// File: rtl/buck_guard_pkg.sv
package buck_guard_pkg;

    typedef enum logic [5:0] {
        ST_RESET     = 6'b000001,
        ST_SOFTSTART = 6'b000010,
        ST_RUN       = 6'b000100,
        ST_OC_RETRY  = 6'b001000,
        ST_OTP_WAIT  = 6'b010000,
        ST_LATCHED   = 6'b100000
    } seq_state_e;

    localparam int NUM_PHASES = 2;

endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
    parameter int HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flag_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } filt_t;

    filt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!raw_i) begin
            r_d.cnt  = '0;
            r_d.flag = 1'b0;
        end else if (r_q.cnt == LAST) begin
            r_d.flag = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flag_o = r_q.flag;

    assert_flag_needs_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(raw_i));
    assert_flag_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !raw_i) |=> !flag_o);
endmodule

// File: rtl/phase_mode.sv
module phase_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic por_ok,
    input  logic ss_low,
    input  logic one_phase_req,
    input  logic supply2_ok,
    output logic single_o
);
    logic single_d, single_q;

    always_comb begin
        if (!por_ok || ss_low) begin
            single_d = 1'b0;
        end else begin
            single_d = single_q || one_phase_req || !supply2_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_q <= 1'b0;
        end else begin
            single_q <= single_d;
        end
    end

    assign single_o = single_q;

    assert_single_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (single_q && por_ok && !ss_low) |=> single_q);
    assert_single_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_ok || ss_low) |=> !single_q);
endmodule

// File: rtl/buck_guard_seq.sv
module buck_guard_seq
    import buck_guard_pkg::*;
#(
    parameter int HOLD_CYC = 200,
    parameter int OC_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok,
    input  logic       ss_low,
    input  logic       ss_done,
    input  logic       ramp_at_fb,
    input  logic       uv_flag_in,
    input  logic       ov_flag_in,
    input  logic       oc_flag_in,
    input  logic       ot_flag_in,
    input  logic       pg_level,
    input  logic       one_phase_req,
    input  logic       supply2_ok,
    output logic       ramp_en,
    output logic       ramp_dischg,
    output logic       comp_pulldown,
    output logic [1:0] sw_en,
    output logic [1:0] lowside_force,
    output logic       drv_off_all,
    output logic       pwr_good,
    output logic       single_phase
);
    localparam int NP  = NUM_PHASES;
    localparam int OCW = $clog2(OC_LIMIT + 1);
    localparam logic [OCW-1:0] OC_LAST = OCW'(OC_LIMIT - 1);

    typedef struct packed {
        seq_state_e     state;
        logic [OCW-1:0] oc_cnt;
        logic           started;
        logic           ramp_en;
        logic           ramp_dischg;
        logic           comp_pd;
        logic [NP-1:0]  sw_en;
        logic [NP-1:0]  ls_force;
        logic           drv_off;
        logic           pgood;
    } seq_t;

    seq_t r_d, r_q;

    logic          uv_filt;
    logic          ov_filt;
    logic          single_w;
    logic [NP-1:0] phase_allow;

    persist_filter #(.HOLD_CYC(HOLD_CYC)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(uv_flag_in), .flag_o(uv_filt)
    );

    persist_filter #(.HOLD_CYC(HOLD_CYC)) u_ov_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(ov_flag_in), .flag_o(ov_filt)
    );

    phase_mode u_phase_mode (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ss_low(ss_low),
        .one_phase_req(one_phase_req), .supply2_ok(supply2_ok),
        .single_o(single_w)
    );

    for (genvar p = 0; p < NP; p++) begin : g_phase
        if (p == 0) begin : g_primary
            assign phase_allow[p] = 1'b1;
        end else begin : g_secondary
            assign phase_allow[p] = !single_w;
        end
    end

    always_comb begin
        logic active;
        r_d = r_q;

        if (!por_ok) begin
            r_d.state  = ST_RESET;
            r_d.oc_cnt = '0;
        end else begin
            case (r_q.state)
                ST_RESET: begin
                    if (!ss_low && !ot_flag_in) begin
                        r_d.state = ST_SOFTSTART;
                    end
                end
                ST_SOFTSTART, ST_RUN: begin
                    if (ss_low) begin
                        r_d.state = ST_RESET;
                    end else if (ot_flag_in) begin
                        r_d.state = ST_OTP_WAIT;
                    end else if (oc_flag_in) begin
                        r_d.oc_cnt = r_q.oc_cnt + OCW'(1);
                        r_d.state  = (r_q.oc_cnt == OC_LAST) ? ST_LATCHED : ST_OC_RETRY;
                    end else if (r_q.state == ST_RUN && uv_filt) begin
                        r_d.state = ST_LATCHED;
                    end else if (r_q.state == ST_SOFTSTART && ss_done) begin
                        r_d.state = ST_RUN;
                    end
                end
                ST_OC_RETRY: begin
                    if (!oc_flag_in) begin
                        r_d.state = ST_RESET;
                    end
                end
                ST_OTP_WAIT: begin
                    if (!ot_flag_in) begin
                        r_d.state = ST_RESET;
                    end
                end
                ST_LATCHED: begin
                    r_d.state = ST_LATCHED;
                end
                default: begin
                    r_d.state = ST_RESET;
                end
            endcase
        end

        active        = (r_d.state == ST_SOFTSTART) || (r_d.state == ST_RUN);
        r_d.started   = active && (r_q.started || ramp_at_fb);
        r_d.ramp_en     = active;
        r_d.ramp_dischg = !active;
        r_d.drv_off     = !active;
        r_d.comp_pd     = !(active && r_d.started);
        for (int p = 0; p < NP; p++) begin
            r_d.sw_en[p]    = active && r_d.started && !ov_filt && phase_allow[p];
            r_d.ls_force[p] = active && ov_filt;
        end
        r_d.pgood = (r_d.state == ST_RUN) && pg_level && !ov_filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state       <= ST_RESET;
            r_q.oc_cnt      <= '0;
            r_q.started     <= 1'b0;
            r_q.ramp_en     <= 1'b0;
            r_q.ramp_dischg <= 1'b1;
            r_q.comp_pd     <= 1'b1;
            r_q.sw_en       <= '0;
            r_q.ls_force    <= '0;
            r_q.drv_off     <= 1'b1;
            r_q.pgood       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ramp_en       = r_q.ramp_en;
    assign ramp_dischg   = r_q.ramp_dischg;
    assign comp_pulldown = r_q.comp_pd;
    assign sw_en         = r_q.sw_en;
    assign lowside_force = r_q.ls_force;
    assign drv_off_all   = r_q.drv_off;
    assign pwr_good      = r_q.pgood;
    assign single_phase  = single_w;

    assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(r_q.state) == 1);
    assert_idle_on_por_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (drv_off_all && sw_en == '0 && !ramp_en));
    assert_switch_needs_ramp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en != '0) |-> (ramp_en && !comp_pulldown));
    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LATCHED && por_ok) |=> (r_q.state == ST_LATCHED));
    assert_no_cross_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en & lowside_force) == '0);
    assert_oc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.oc_cnt <= OCW'(OC_LIMIT));
    assert_pgood_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (r_q.state == ST_RUN && !drv_off_all));
    assert_phase2_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(single_phase) |-> !sw_en[1]);
endmodule

// File: tb/buck_guard_seq_bench.sv
module buck_guard_seq_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HOLD = 4;
    localparam int  NVEC = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok = 1'b0, ss_low = 1'b0, ss_done = 1'b0, ramp_at_fb = 1'b0;
    logic uv_flag_in = 1'b0, ov_flag_in = 1'b0, oc_flag_in = 1'b0, ot_flag_in = 1'b0;
    logic pg_level = 1'b0, one_phase_req = 1'b0, supply2_ok = 1'b1;
    logic ramp_en, ramp_dischg, comp_pulldown, drv_off_all, pwr_good, single_phase;
    logic [1:0] sw_en, lowside_force;
    logic [9:0] obs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    buck_guard_seq #(.HOLD_CYC(HOLD), .OC_LIMIT(3)) u_buck_guard_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ss_low(ss_low),
        .ss_done(ss_done), .ramp_at_fb(ramp_at_fb), .uv_flag_in(uv_flag_in),
        .ov_flag_in(ov_flag_in), .oc_flag_in(oc_flag_in), .ot_flag_in(ot_flag_in),
        .pg_level(pg_level), .one_phase_req(one_phase_req), .supply2_ok(supply2_ok),
        .ramp_en(ramp_en), .ramp_dischg(ramp_dischg), .comp_pulldown(comp_pulldown),
        .sw_en(sw_en), .lowside_force(lowside_force), .drv_off_all(drv_off_all),
        .pwr_good(pwr_good), .single_phase(single_phase)
    );

    // observed: {ramp_en, ramp_dischg, comp_pulldown, sw_en[1:0], lowside_force[1:0], drv_off_all, pwr_good, single_phase}
    assign obs = {ramp_en, ramp_dischg, comp_pulldown, sw_en, lowside_force,
                  drv_off_all, pwr_good, single_phase};

    // entry: {req[3:0], inputs[10:0], wait[7:0], expected[9:0]}
    // inputs: {por, ss_low, ss_done, ramp_at_fb, uv, ov, oc, ot, pg, one_phase_req, supply2_ok}
    localparam logic [32:0] VEC [NVEC] = '{
        {4'd2,  11'b10000000001, 8'd8, 10'b1010000000}, // R2 ramp on, pre-charge hold
        {4'd2,  11'b10010000001, 8'd8, 10'b1001100000}, // R2 ramp reached fb
        {4'd2,  11'b10110000001, 8'd8, 10'b1001100000}, // R2 run
        {4'd8,  11'b10110000101, 8'd8, 10'b1001100010}, // R8 power good
        {4'd3,  11'b10111000101, 8'd3, 10'b1001100010}, // R3 short uv pulse
        {4'd3,  11'b10110000101, 8'd8, 10'b1001100010}, // R3 still running
        {4'd5,  11'b10110100101, 8'd8, 10'b1000011000}, // R5 ov clamp
        {4'd5,  11'b10110000101, 8'd8, 10'b1001100010}, // R5 ov released
        {4'd9,  11'b10110000111, 8'd8, 10'b1000100011}, // R9 single request
        {4'd9,  11'b10110000101, 8'd8, 10'b1000100011}, // R9 sticky
        {4'd10, 11'b11110000101, 8'd8, 10'b0110000100}, // R10 ss low
        {4'd2,  11'b10000000001, 8'd8, 10'b1010000000}, // R2 restart
        {4'd9,  11'b10000000000, 8'd8, 10'b1010000001}, // R9 second supply absent
        {4'd4,  11'b10001000001, 8'd8, 10'b1010000001}, // R4 uv blanked in soft-start
        {4'd6,  11'b10000010001, 8'd8, 10'b0110000101}, // R6 oc event 1
        {4'd6,  11'b10000000001, 8'd8, 10'b1010000001}, // R6 retry soft-start
        {4'd6,  11'b10000010001, 8'd8, 10'b0110000101}, // R6 oc event 2
        {4'd6,  11'b10000000001, 8'd8, 10'b1010000001}, // R6 retry
        {4'd7,  11'b10000001001, 8'd8, 10'b0110000101}, // R7 over-temperature
        {4'd7,  11'b10000000001, 8'd8, 10'b1010000001}, // R7 restart after cool
        {4'd6,  11'b10000010001, 8'd8, 10'b0110000101}, // R6 oc event 3 latches
        {4'd6,  11'b10000000001, 8'd8, 10'b0110000101}, // R6 stays latched
        {4'd6,  11'b11000000001, 8'd8, 10'b0110000100}, // R6 ss low keeps latch
        {4'd1,  11'b00000000001, 8'd8, 10'b0110000100}, // R1 por low
        {4'd1,  11'b10000000001, 8'd8, 10'b1010000000}, // R1 latch cleared
        {4'd1,  11'b10000010001, 8'd8, 10'b0110000100}, // R1 count cleared: retry
        {4'd6,  11'b10000000001, 8'd8, 10'b1010000000}, // R6 not latched
        {4'd2,  11'b10110000001, 8'd8, 10'b1001100000}, // R2 run again
        {4'd4,  11'b10111000001, 8'd8, 10'b0110000100}, // R4 uv in run latches
        {4'd4,  11'b10110000001, 8'd8, 10'b0110000100}, // R4 uv latch holds
        {4'd1,  11'b00110000001, 8'd8, 10'b0110000100}, // R1 por low
        {4'd4,  11'b10110000001, 8'd8, 10'b1001100000}, // R4 fresh start-up
        {4'd10, 11'b11110000001, 8'd8, 10'b0110000100}, // R10 ss low
        {4'd8,  11'b10000000101, 8'd8, 10'b1010000000}, // R8 no pgood in soft-start
        {4'd5,  11'b10000100101, 8'd8, 10'b1010011000}, // R5 ov in soft-start
        {4'd5,  11'b10000000101, 8'd8, 10'b1010000000}  // R5 released
    };

    task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        step(3);
        check(1, obs, 10'b0110000100, "reset state");   // R1
        rst_n = 1'b1;
        step(2);
        check(1, obs, 10'b0110000100, "por low idle");  // R1

        for (int i = 0; i < NVEC; i++) begin
            {por_ok, ss_low, ss_done, ramp_at_fb, uv_flag_in, ov_flag_in,
             oc_flag_in, ot_flag_in, pg_level, one_phase_req, supply2_ok} = VEC[i][28:18];
            step(int'(VEC[i][17:10]));
            check(int'(VEC[i][32:29]), obs, VEC[i][9:0], $sformatf("vector %0d", i));
        end

        // R3 filter length: clamp only after HOLD samples, release after one
        ov_flag_in = 1'b1;
        step(HOLD);
        check(3, {8'd0, lowside_force}, 10'b0000000000, "ov before window");
        step(1);
        check(3, {8'd0, lowside_force}, 10'b0000000011, "ov after window");
        ov_flag_in = 1'b0;
        step(1);
        check(5, {8'd0, lowside_force}, 10'b0000000011, "ov release latency");
        step(1);
        check(5, {8'd0, lowside_force}, 10'b0000000000, "ov released");

        // R2 single-cycle response of the registered outputs
        por_ok = 1'b0;
        step(1);
        check(1, obs, 10'b0110000100, "por drop latency");
        por_ok = 1'b1;
        step(1);
        check(2, obs, 10'b1010000000, "start latency");

        // R1 asynchronous reset mid-operation
        #(CLK_PERIOD / 4);
        rst_n = 1'b0;
        #(CLK_PERIOD / 8);
        check(1, obs, 10'b0110000100, "async reset");
        rst_n = 1'b1;
        step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule